// File: doc/BRIEF.md
# Consecutive-Ones Run Detector With Trailing Hold

This block watches an endless serial bit stream and examines one bit on each clock where the qualifier is high. Its single output goes high in any examined cycle where the current bit and the bit before it are both 1. It also goes high when the two bits before the current one were both 1, whatever the current bit is. The effect is that every run of two or more ones holds the output high for the length of the run after its first bit. It then holds the output for one more examined bit after the run ends. A lone "11" therefore gives two output ones.

The history lives in a three-state machine. Its states are: no recent one, one trailing 1, and two or more trailing 1s. A control module holds that state and hands a small bundle of strobes to a datapath module. The datapath combines the strobes with the live input bit to form the output in the same cycle, so the output is Mealy-style. Cycles where the qualifier is low do not count as stream bits. In those cycles the history is frozen and the output is held at 0.

Top module: `pair_run_detect`

## Requirements
- R1: A synchronous active-high reset returns the history to "no recent one". Bits seen before the reset can never take part in a pair with bits seen after it, so the first two qualified bits after reset give output 0, 1 only if both are 1.
- R2: In a qualified cycle whose bit is 1, when the previous qualified bit was also 1, the output is 1 in that same cycle.
- R3: In a qualified cycle where the two previous qualified bits were both 1, the output is 1 whatever the current bit is.
- R4: In a qualified cycle where neither R2 nor R3 applies, the output is 0. For example, the alternating stream 1,0,1,0 gives all zeros.
- R5: In a cycle with the qualifier low, the output is 0 and the history is unchanged. The next qualified bit pairs with the last qualified bit from before the gap.
- R6: For the qualified stream 0,1,1,1,0,0, the outputs are 0,0,1,1,1,0. A run of ones keeps the output high through its tail and for exactly one qualified bit after it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | High when bitIn carries a stream bit this cycle |
| bitIn | input | 1 | Current serial stream bit |
| detOut | output | 1 | Detection output, combinational from state and inputs |

## Verification
Two conditions can fall in one cycle. The first is the fresh-pair condition, where the current bit is 1 after a 1. The second is the trailing-hold condition, where the previous two bits were 1s. A run of three or more ones makes both true on its third bit. The bench drives such runs and checks for a single high output with no gap as the run continues. It also places a qualifier-low cycle in the middle of a run. There, the hold and the gating meet: the output must drop to 0 for the gap cycle, and the trailing hold must then appear on the next qualified bit.

// File: rtl/pair_run_pkg.sv
package pair_run_pkg;

  typedef enum logic [1:0] {
    HIST_NONE = 2'd0,
    HIST_ONE  = 2'd1,
    HIST_TWO  = 2'd2
  } runHist_t;

  typedef struct packed {
    logic takeBit;   // a stream bit is examined this cycle
    logic lastOne;   // previous examined bit was 1
    logic lastPair;  // previous two examined bits were 1
  } runStrobes_t;

endpackage

// File: rtl/pair_run_ctrl.sv
module pair_run_ctrl
  import pair_run_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        bitValid,
  input  logic        bitIn,
  output runStrobes_t strobes
);

  runHist_t histQ;
  runHist_t histD;

  always_comb begin
    histD = histQ;
    if (bitValid) begin
      if (!bitIn) begin
        histD = HIST_NONE;
      end else begin
        case (histQ)
          HIST_NONE: histD = HIST_ONE;
          HIST_ONE:  histD = HIST_TWO;
          HIST_TWO:  histD = HIST_TWO;
          default:   histD = HIST_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) histQ <= HIST_NONE;
    else     histQ <= histD;
  end

  always_comb begin
    strobes.takeBit  = bitValid;
    strobes.lastOne  = (histQ == HIST_ONE) || (histQ == HIST_TWO);
    strobes.lastPair = (histQ == HIST_TWO);
  end

endmodule

// File: rtl/pair_run_dp.sv
module pair_run_dp
  import pair_run_pkg::*;
(
  input  runStrobes_t strobes,
  input  logic        bitIn,
  output logic        detOut
);

  logic freshPair;
  logic tailHold;

  always_comb begin
    freshPair = strobes.lastOne & bitIn;
    tailHold  = strobes.lastPair;
    detOut    = strobes.takeBit & (freshPair | tailHold);
  end

endmodule

// File: rtl/pair_run_detect.sv
module pair_run_detect
  import pair_run_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bitValid,
  input  logic bitIn,
  output logic detOut
);

  runStrobes_t strobes;

  pair_run_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .strobes  (strobes)
  );

  pair_run_dp u_dp (
    .strobes (strobes),
    .bitIn   (bitIn),
    .detOut  (detOut)
  );

endmodule

// File: rtl/pair_run_detect_chk.sv
module pair_run_detect_chk (
  input logic clk,
  input logic rst,
  input logic bitValid,
  input logic bitIn,
  input logic detOut
);

  logic prevBit1;
  logic prevBit2;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevBit1 <= 1'b0;
      prevBit2 <= 1'b0;
    end else if (bitValid) begin
      prevBit2 <= prevBit1;
      prevBit1 <= bitIn;
    end
  end

  // R5
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bitValid |-> !detOut);

  // R2
  fresh_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (bitValid && bitIn && prevBit1) |-> detOut);

  // R3
  tail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bitValid && prevBit1 && prevBit2) |-> detOut);

  // R4
  no_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (bitValid && !(bitIn && prevBit1) && !(prevBit1 && prevBit2)) |-> !detOut);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !detOut);

endmodule

bind pair_run_detect pair_run_detect_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bitValid (bitValid),
  .bitIn    (bitIn),
  .detOut   (detOut)
);

// File: tb/test_pair_run_detect.sv
`timescale 1ns/1ps
module test_pair_run_detect;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitValid = 1'b0;
  logic bitIn = 1'b0;
  logic detOut;

  int vecCount = 0;
  int errCount = 0;
  bit doneFlag = 1'b0;

  always #4 clk = ~clk;

  pair_run_detect i_pair_run_detect (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .detOut   (detOut)
  );

  task automatic applyBit(input logic v, input logic b, input logic expOut,
                          input string req);
    @(negedge clk);
    bitValid = v;
    bitIn    = b;
    #1;
    vecCount++;
    if (detOut !== expOut) begin
      errCount++;
      $display("FAIL %s: v=%0b b=%0b detOut=%0b expected=%0b", req, v, b, detOut, expOut);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; bitValid = 1'b0; bitIn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: reset state and clearing of pre-reset history
  task automatic testReset();
    #1;
    vecCount++;
    if (detOut !== 1'b0) begin
      errCount++;
      $display("FAIL R1: detOut=%0b expected=0 in reset", detOut);
    end
    doReset();
    applyBit(1, 1, 0, "R1");
    applyBit(1, 1, 1, "R1");
    applyBit(1, 1, 1, "R1");
    doReset();
    applyBit(1, 1, 0, "R1");
    applyBit(1, 0, 0, "R1");
  endtask

  // R6, R2, R3: reference run 0,1,1,1,0,0
  task automatic testRun();
    doReset();
    applyBit(1, 0, 0, "R6");
    applyBit(1, 1, 0, "R6");
    applyBit(1, 1, 1, "R2");
    applyBit(1, 1, 1, "R6");
    applyBit(1, 0, 1, "R3");
    applyBit(1, 0, 0, "R6");
  endtask

  // R4: isolated ones never fire
  task automatic testAlternate();
    doReset();
    applyBit(1, 1, 0, "R4");
    applyBit(1, 0, 0, "R4");
    applyBit(1, 1, 0, "R4");
    applyBit(1, 0, 0, "R4");
    applyBit(1, 1, 0, "R4");
  endtask

  // R3: single pair then a 1 after the gap of one zero
  task automatic testShortPair();
    doReset();
    applyBit(1, 1, 0, "R2");
    applyBit(1, 1, 1, "R2");
    applyBit(1, 0, 1, "R3");
    applyBit(1, 1, 0, "R4");
    applyBit(1, 0, 0, "R4");
  endtask

  // R5: qualifier low freezes history and forces zero
  task automatic testGaps();
    doReset();
    applyBit(1, 1, 0, "R5");
    applyBit(0, 1, 0, "R5");
    applyBit(0, 0, 0, "R5");
    applyBit(1, 1, 1, "R5");
    applyBit(0, 1, 0, "R5");
    applyBit(1, 0, 1, "R5");
    applyBit(0, 1, 0, "R5");
    applyBit(1, 1, 0, "R5");
  endtask

  initial begin
    testReset();
    testRun();
    testAlternate();
    testShortPair();
    testGaps();
    doneFlag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!doneFlag) begin
      errCount++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

endmodule